// File: doc/BRIEF.md
# Two-Channel Over-Temperature Alarm with Hysteresis

This block compares a local and a remote temperature reading against a programmable limit for each channel. It produces an active-low alarm pin drive, sticky per-channel status flags, an interrupt request and a request for full fan speed. Each channel's alarm condition latches when its reading passes the limit. The latch releases only after the reading drops more than five degrees below that limit. A status-read strobe clears the flags. A cleared flag stays silent until the same hysteresis release has been seen, even if the reading is still above the limit.

The shared alarm pin can also work as an input. In that mode an external device pulls it low to demand full fan speed. The input is synchronised and reported as a non-sticky status bit. A separate sensor-failure input sets a flag that holds until reset. That flag drives a second alarm output, which is tri-stated whenever its enable is off. All outputs that go to pads are expressed as pull-low enables: a 1 means the pad is driven low and a 0 means it is released.

Top module: `thermal_limit_alarm`

## Requirements
- R1: Temperatures and limits are 8-bit two's-complement whole degrees. When a channel's reading is strictly greater than its limit at a clock edge, that channel's flag becomes 1 after that edge and `alarmPinDrive` becomes 1, provided the channel is armed. A reading equal to the limit sets nothing.
- R2: A channel's alarm hold is set on any over-limit edge. It is released only at an edge where the reading is strictly below the limit minus 5. `alarmPinDrive` is 1 while any channel holds or any channel flag is 1. A status read does not release it.
- R3: A `statusRead` pulse clears both channel flags after that edge. A channel whose flag was 1, or whose reading was over its limit, at that edge becomes disarmed. A disarmed channel does not set its flag again until an edge where its reading is below the limit minus 5.
- R4: If `statusRead` and a new over-limit condition meet at the same edge, the flag stays 0 and the channel is disarmed as in R3.
- R5: `intPinDrive` is 1 when a channel flag is 1 and `intEn` is 1, or when the failure flag is 1 and `failIntEn` is 1. Otherwise it is 0. `alarmPinDrive` does not depend on either enable.
- R6: With `pinAsInput` = 0, `forceFull` equals `alarmPinDrive` when `fanForceEn` is 1. It is 0 from the alarm path when `fanForceEn` is 0.
- R7: With `pinAsInput` = 1, `alarmPinDrive` is 0. A low `extAlarmN` reaches `flagExtIn` after the second clock edge and sets `forceFull` to 1 whatever `fanForceEn` is. A high `extAlarmN` clears it after the same delay.
- R8: A 1 on `sensorFail` at an edge sets `flagFail`. The flag stays 1 until reset even after `sensorFail` returns to 0. A status read does not clear it.
- R9: `failPinDrive` is 1 only when `flagFail` is 1 and `failOutEn` is 1. With `failOutEn` = 0 it is 0, which means high impedance.
- R10: The release threshold limit minus 5 saturates at -128. With a limit of -126, a reading of -128 never releases the hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tempLocal | input | 8 | Local reading, signed degrees |
| tempRemote | input | 8 | Remote reading, signed degrees |
| limLocal | input | 8 | Local limit, signed degrees |
| limRemote | input | 8 | Remote limit, signed degrees |
| statusRead | input | 1 | One-cycle status read strobe, clears flags |
| intEn | input | 1 | Interrupt enable for limit flags |
| failIntEn | input | 1 | Interrupt enable for the failure flag |
| fanForceEn | input | 1 | Alarm forces full fan speed when 1 |
| pinAsInput | input | 1 | Alarm pin used as an external input when 1 |
| extAlarmN | input | 1 | Sampled level of the alarm pin, active low |
| sensorFail | input | 1 | Remote sensor failure indication |
| failOutEn | input | 1 | Enable for the failure alarm output |
| alarmPinDrive | output | 1 | Pull alarm pin low |
| intPinDrive | output | 1 | Pull interrupt pin low |
| failPinDrive | output | 1 | Pull failure pin low (0 = high impedance) |
| flagLocal | output | 1 | Local over-limit status flag |
| flagRemote | output | 1 | Remote over-limit status flag |
| flagExtIn | output | 1 | External alarm input status |
| flagFail | output | 1 | Sticky sensor failure flag |
| forceFull | output | 1 | Request 100% PWM duty |

## Verification
A status-read strobe and a fresh over-limit condition on the same channel can meet at one clock edge. The bench drives the reading above the limit and raises the read strobe on the same falling edge. After the rising edge it expects the flag to read 0 while the alarm pin is still driven. It then holds the reading over the limit and expects no new flag. The flag may only return after the reading has dipped below the hysteresis threshold and climbed again.

// File: rtl/tla_pkg.sv
package tla_pkg;
  localparam int NumCh = 2;
  localparam int ChLocal = 0;
  localparam int ChRemote = 1;

  typedef struct packed {
    logic [NumCh-1:0] over;
    logic [NumCh-1:0] below;
    logic             extLow;
  } cmp_t;
endpackage

// File: rtl/tla_datapath.sv
module tla_datapath
  import tla_pkg::*;
#(
  parameter int TEMP_W = 8,
  parameter int HYST   = 5,
  parameter int SYNC_N = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NumCh-1:0][TEMP_W-1:0]  temps,
  input  logic [NumCh-1:0][TEMP_W-1:0]  limits,
  input  logic                          extAlarmN,
  output cmp_t                          cmp
);
  localparam logic signed [TEMP_W:0] MinExt  = {2'b11, {(TEMP_W-1){1'b0}}};
  localparam logic signed [TEMP_W:0] HystExt = (TEMP_W+1)'(HYST);

  logic [SYNC_N-1:0] syncQ;

  for (genvar c = 0; c < NumCh; c++) begin : g_cmp
    logic signed [TEMP_W:0]   diffExt;
    logic signed [TEMP_W-1:0] relThr;
    always_comb begin
      diffExt = $signed({limits[c][TEMP_W-1], limits[c]}) - HystExt;
      relThr  = (diffExt < MinExt) ? MinExt[TEMP_W-1:0] : diffExt[TEMP_W-1:0];
    end
    assign cmp.over[c]  = $signed(temps[c]) > $signed(limits[c]);
    assign cmp.below[c] = $signed(temps[c]) < relThr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_N-2:0], ~extAlarmN};
  end

  assign cmp.extLow = syncQ[SYNC_N-1];
endmodule

// File: rtl/tla_control.sv
module tla_control
  import tla_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  cmp_t             cmp,
  input  logic             statusRead,
  input  logic             intEn,
  input  logic             failIntEn,
  input  logic             fanForceEn,
  input  logic             pinAsInput,
  input  logic             sensorFail,
  input  logic             failOutEn,
  output logic [NumCh-1:0] flagV,
  output logic             flagExtIn,
  output logic             flagFail,
  output logic             alarmPinDrive,
  output logic             intPinDrive,
  output logic             failPinDrive,
  output logic             forceFull
);
  logic [NumCh-1:0] holdV;
  logic             failQ;

  for (genvar c = 0; c < NumCh; c++) begin : g_ch
    logic flagQ, armQ, holdQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        flagQ <= 1'b0;
        armQ  <= 1'b1;
        holdQ <= 1'b0;
      end else begin
        if (cmp.over[c])       holdQ <= 1'b1;
        else if (cmp.below[c]) holdQ <= 1'b0;
        if (statusRead) begin
          flagQ <= 1'b0;
          if (flagQ || cmp.over[c]) armQ <= 1'b0;
        end else begin
          if (cmp.below[c])          armQ  <= 1'b1;
          if (cmp.over[c] && armQ)   flagQ <= 1'b1;
        end
      end
    end
    assign flagV[c] = flagQ;
    assign holdV[c] = holdQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) failQ <= 1'b0;
    else       failQ <= failQ | sensorFail;
  end

  assign flagFail      = failQ;
  assign flagExtIn     = pinAsInput & cmp.extLow;
  assign alarmPinDrive = ~pinAsInput & ((|holdV) | (|flagV));
  assign intPinDrive   = (intEn & (|flagV)) | (failIntEn & failQ);
  assign failPinDrive  = failOutEn & failQ;
  assign forceFull     = flagExtIn | (fanForceEn & alarmPinDrive);
endmodule

// File: rtl/thermal_limit_alarm.sv
module thermal_limit_alarm
  import tla_pkg::*;
#(
  parameter int TEMP_W = 8,
  parameter int HYST   = 5,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TEMP_W-1:0] tempLocal,
  input  logic [TEMP_W-1:0] tempRemote,
  input  logic [TEMP_W-1:0] limLocal,
  input  logic [TEMP_W-1:0] limRemote,
  input  logic              statusRead,
  input  logic              intEn,
  input  logic              failIntEn,
  input  logic              fanForceEn,
  input  logic              pinAsInput,
  input  logic              extAlarmN,
  input  logic              sensorFail,
  input  logic              failOutEn,
  output logic              alarmPinDrive,
  output logic              intPinDrive,
  output logic              failPinDrive,
  output logic              flagLocal,
  output logic              flagRemote,
  output logic              flagExtIn,
  output logic              flagFail,
  output logic              forceFull
);
  logic [NumCh-1:0][TEMP_W-1:0] temps, limits;
  logic [NumCh-1:0]             flagV;
  cmp_t                         cmp;

  assign temps[ChLocal]   = tempLocal;
  assign temps[ChRemote]  = tempRemote;
  assign limits[ChLocal]  = limLocal;
  assign limits[ChRemote] = limRemote;

  tla_datapath #(.TEMP_W(TEMP_W), .HYST(HYST), .SYNC_N(SYNC_N)) u_dp (
    .clk(clk), .rstN(rstN), .temps(temps), .limits(limits),
    .extAlarmN(extAlarmN), .cmp(cmp)
  );

  tla_control u_ctl (
    .clk(clk), .rstN(rstN), .cmp(cmp), .statusRead(statusRead),
    .intEn(intEn), .failIntEn(failIntEn), .fanForceEn(fanForceEn),
    .pinAsInput(pinAsInput), .sensorFail(sensorFail), .failOutEn(failOutEn),
    .flagV(flagV), .flagExtIn(flagExtIn), .flagFail(flagFail),
    .alarmPinDrive(alarmPinDrive), .intPinDrive(intPinDrive),
    .failPinDrive(failPinDrive), .forceFull(forceFull)
  );

  assign flagLocal  = flagV[ChLocal];
  assign flagRemote = flagV[ChRemote];
endmodule

// File: rtl/tla_checker.sv
module tla_checker #(
  parameter int TEMP_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [TEMP_W-1:0] tempLocal,
  input logic [TEMP_W-1:0] limLocal,
  input logic              statusRead,
  input logic              intEn,
  input logic              failIntEn,
  input logic              fanForceEn,
  input logic              pinAsInput,
  input logic              failOutEn,
  input logic              alarmPinDrive,
  input logic              intPinDrive,
  input logic              failPinDrive,
  input logic              flagLocal,
  input logic              flagRemote,
  input logic              flagExtIn,
  input logic              flagFail,
  input logic              forceFull
);
  // R1: a local flag only rises after an over-limit reading
  p_set_on_over_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagLocal) |-> $past($signed(tempLocal) > $signed(limLocal)));

  // R2: a set flag keeps the alarm pin driven while the pin is an output
  p_flag_drives_pin_r2: assert property (@(posedge clk) disable iff (!rstN)
    (flagLocal || flagRemote) && !pinAsInput |-> alarmPinDrive);

  // R3 and R4: a read leaves both flags clear
  p_read_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    statusRead |=> !flagLocal && !flagRemote);

  // R5: with both enables off the interrupt pin stays released
  p_int_gated_r5: assert property (@(posedge clk) disable iff (!rstN)
    !intEn && !failIntEn |-> !intPinDrive);

  // R6: without fan-force and without an external demand no full speed
  p_fan_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    !fanForceEn && !flagExtIn |-> !forceFull);

  // R7: in input mode the alarm pin is never driven
  p_input_mode_r7: assert property (@(posedge clk) disable iff (!rstN)
    pinAsInput |-> !alarmPinDrive);

  // R8: the failure flag never falls while out of reset
  p_fail_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    flagFail |=> flagFail);

  // R9: a disabled failure output is left floating
  p_fail_hiz_r9: assert property (@(posedge clk) disable iff (!rstN)
    !failOutEn |-> !failPinDrive);
endmodule

bind thermal_limit_alarm tla_checker #(.TEMP_W(TEMP_W)) u_chk (
  .clk(clk), .rstN(rstN), .tempLocal(tempLocal), .limLocal(limLocal),
  .statusRead(statusRead), .intEn(intEn), .failIntEn(failIntEn),
  .fanForceEn(fanForceEn), .pinAsInput(pinAsInput), .failOutEn(failOutEn),
  .alarmPinDrive(alarmPinDrive), .intPinDrive(intPinDrive),
  .failPinDrive(failPinDrive), .flagLocal(flagLocal), .flagRemote(flagRemote),
  .flagExtIn(flagExtIn), .flagFail(flagFail), .forceFull(forceFull)
);

// File: tb/sim_thermal_limit_alarm.sv
`timescale 1ns/1ps
module sim_thermal_limit_alarm;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] tempLocal = 8'd25, tempRemote = 8'd25;
  logic [7:0] limLocal = 8'd80, limRemote = 8'd90;
  logic statusRead = 0, intEn = 0, failIntEn = 0, fanForceEn = 0;
  logic pinAsInput = 0, extAlarmN = 1, sensorFail = 0, failOutEn = 0;
  logic alarmPinDrive, intPinDrive, failPinDrive, flagLocal, flagRemote;
  logic flagExtIn, flagFail, forceFull;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  thermal_limit_alarm u0 (
    .clk(clk), .rstN(rstN), .tempLocal(tempLocal), .tempRemote(tempRemote),
    .limLocal(limLocal), .limRemote(limRemote), .statusRead(statusRead),
    .intEn(intEn), .failIntEn(failIntEn), .fanForceEn(fanForceEn),
    .pinAsInput(pinAsInput), .extAlarmN(extAlarmN), .sensorFail(sensorFail),
    .failOutEn(failOutEn), .alarmPinDrive(alarmPinDrive),
    .intPinDrive(intPinDrive), .failPinDrive(failPinDrive),
    .flagLocal(flagLocal), .flagRemote(flagRemote), .flagExtIn(flagExtIn),
    .flagFail(flagFail), .forceFull(forceFull)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0;
    tempLocal = 8'd25; tempRemote = 8'd25; limLocal = 8'd80; limRemote = 8'd90;
    statusRead = 0; intEn = 0; failIntEn = 0; fanForceEn = 0;
    pinAsInput = 0; extAlarmN = 1; sensorFail = 0; failOutEn = 0;
    step();
    rstN = 1;
    step();
  endtask

  task automatic readPulse();
    statusRead = 1; step(); statusRead = 0;
  endtask

  task automatic t_reset_state();
    doReset();
    chk("R1", "reset alarm", alarmPinDrive, 0);
    chk("R5", "reset int", intPinDrive, 0);
    chk("R8", "reset failFlag", flagFail, 0);
    chk("R1", "reset flags", flagLocal | flagRemote, 0);
    chk("R6", "reset forceFull", forceFull, 0);
  endtask

  task automatic t_set_and_hyst();
    doReset();
    tempLocal = 8'd80; step();
    chk("R1", "equal to limit no flag", flagLocal, 0);
    tempLocal = 8'd81; step();
    chk("R1", "over sets flag", flagLocal, 1);
    chk("R1", "over drives alarm", alarmPinDrive, 1);
    readPulse();
    chk("R3", "read clears flag", flagLocal, 0);
    tempLocal = 8'd75; step();
    chk("R2", "at limit-5 still held", alarmPinDrive, 1);
    tempLocal = 8'd74; step();
    chk("R2", "below limit-5 releases", alarmPinDrive, 0);
  endtask

  task automatic t_read_rearm();
    doReset();
    intEn = 1;
    tempLocal = 8'd90; step();
    chk("R5", "int with flag and enable", intPinDrive, 1);
    readPulse();
    chk("R3", "flag cleared by read", flagLocal, 0);
    chk("R2", "alarm kept after read", alarmPinDrive, 1);
    step(); step();
    chk("R3", "no re-set while over", flagLocal, 0);
    chk("R3", "int quiet while disarmed", intPinDrive, 0);
    tempLocal = 8'd78; step();
    tempLocal = 8'd90; step();
    chk("R3", "not rearmed above threshold", flagLocal, 0);
    tempLocal = 8'd70; step();
    tempLocal = 8'd90; step();
    chk("R3", "rearmed after dip", flagLocal, 1);
  endtask

  task automatic t_collide();
    doReset();
    tempLocal = 8'd95; statusRead = 1; step(); statusRead = 0;
    chk("R4", "read wins over set", flagLocal, 0);
    chk("R4", "alarm hold still set", alarmPinDrive, 1);
    step();
    chk("R4", "disarmed after collision", flagLocal, 0);
    tempLocal = 8'd60; step();
    tempLocal = 8'd95; step();
    chk("R4", "rearmed after dip", flagLocal, 1);
  endtask

  task automatic t_int_enable();
    doReset();
    tempRemote = 8'd91; step();
    chk("R1", "remote flag set", flagRemote, 1);
    chk("R1", "local flag untouched", flagLocal, 0);
    chk("R5", "int masked", intPinDrive, 0);
    chk("R5", "alarm ignores mask", alarmPinDrive, 1);
    intEn = 1; step();
    chk("R5", "int unmasked", intPinDrive, 1);
  endtask

  task automatic t_fan_force();
    doReset();
    tempLocal = 8'd100; step();
    chk("R6", "no force when disabled", forceFull, 0);
    fanForceEn = 1; step();
    chk("R6", "force with alarm", forceFull, 1);
    tempLocal = 8'd20; readPulse();
    chk("R6", "no force after release", forceFull, 0);
  endtask

  task automatic t_ext_input();
    doReset();
    pinAsInput = 1; tempLocal = 8'd100; step();
    chk("R7", "pin not driven as input", alarmPinDrive, 0);
    chk("R7", "fanForceEn off no force", forceFull, 0);
    extAlarmN = 0; step();
    chk("R7", "one edge not yet seen", flagExtIn, 0);
    step();
    chk("R7", "ext low reported", flagExtIn, 1);
    chk("R7", "ext low forces fan", forceFull, 1);
    extAlarmN = 1; step(); step();
    chk("R7", "ext high cleared", flagExtIn, 0);
  endtask

  task automatic t_sensor_fail();
    doReset();
    failIntEn = 1; sensorFail = 1; step(); sensorFail = 0;
    chk("R8", "fail flag set", flagFail, 1);
    chk("R9", "fail pin floats when disabled", failPinDrive, 0);
    chk("R5", "fail interrupt", intPinDrive, 1);
    readPulse(); step();
    chk("R8", "fail flag sticky", flagFail, 1);
    failOutEn = 1; step();
    chk("R9", "fail pin driven when enabled", failPinDrive, 1);
    doReset();
    chk("R8", "reset clears fail", flagFail, 0);
  endtask

  task automatic t_saturate();
    doReset();
    limLocal = 8'h82; tempLocal = 8'h83; step();
    chk("R10", "over negative limit", alarmPinDrive, 1);
    tempLocal = 8'h80; readPulse(); step();
    chk("R10", "saturated threshold holds", alarmPinDrive, 1);
    limLocal = 8'h88; tempLocal = 8'h82; step();
    chk("R10", "unsaturated release", alarmPinDrive, 0);
  endtask

  initial begin
    #4000000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_set_and_hyst();
    t_read_rearm();
    t_collide();
    t_int_enable();
    t_fan_force();
    t_ext_input();
    t_sensor_fail();
    t_saturate();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule